// File: doc/BRIEF.md
# Field extract and insert unit

The unit performs bit-field operations on a pair of 32-bit operands that are treated as one 64-bit double word, with the left operand in the upper half. The double word is shifted left by a shift count, and the upper 32 bits become the shifted word. Two masks are generated, each with ones in its low-order bits: one from the mask count and one from the shift count. In extract mode only the first mask is applied, so the result holds the low bits of the shifted word and zeros above them. In insert mode the two masks are XORed, and this selects a window of bits. Inside the window the result takes the shifted word, and outside it the result takes the right operand.

The 13-bit field descriptor holds the insert flag, the mask count and the shift count. It comes from one of two registers. One is a field register that loads from the datapath write-back bus when its load strobe is high. The other is an immediate register that captures the immediate bus on every clock. The opcode picks the register. The result and a valid flag are registered. They update only for the two field opcodes, and only when hold is low.

Top module: `field_unit`

## Requirements
- R1: After synchronous reset, `valid_o` is 0 and `result_o` is 0. The field register also clears to 0.
- R2: Descriptor layout is bit 12 insert flag, bits 11:6 mask count and bits 5:0 shift count. With insert flag 0, the result is the shifted word ANDed with a mask holding mask-count ones at the least-significant end.
- R3: The shifted word is the upper 32 bits of {left_i, right_i} shifted left by the shift count. A count of 0 yields left_i and a count of 32 yields right_i.
- R4: With insert flag 1, the window is ones(mask) XOR ones(shift). The result is the shifted word inside the window and right_i outside it.
- R5: A mask count or shift count above 32 acts exactly as 32.
- R6: Opcode 9 takes its descriptor from the field register. That register loads `field_din_i` on a clock edge where `field_load_i` is 1. An opcode 9 in the same cycle as a load still uses the old contents.
- R7: Opcode 10 takes its descriptor from `kimm_i` as captured at the previous clock edge.
- R8: `valid_o` is 1 in the cycle after a clock edge at which `op_i` was 9 or 10 and `hold_i` was 0. Otherwise `valid_o` is 0.
- R9: When the opcode is not 9 or 10, or when `hold_i` is 1, `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Opcode; 9 uses the field register, 10 uses the immediate register |
| left_i | input | 32 | Left (upper) operand |
| right_i | input | 32 | Right (lower) operand, also the insert background |
| kimm_i | input | 13 | Immediate bus, captured every cycle |
| field_din_i | input | 13 | Write-back bus value for the field register |
| field_load_i | input | 1 | Load strobe for the field register |
| hold_i | input | 1 | Suppresses the result update |
| result_o | output | 32 | Registered field result |
| valid_o | output | 1 | Result was written in the last cycle |

## Verification
The bench targets several boundaries:
- Shift counts of 0 and 32. A shifter that takes the wrong half of the double word returns the wrong operand at these counts.
- Counts above 32. An unclamped mask or shifter wraps, or shifts in zeros instead of right_i.
- Insert windows whose edges come from both counts. A design that ORs the masks instead of XORing them, or that drops the right-operand background, corrupts the bits outside the window.
- Descriptor timing. A design that bypasses the immediate register, or that forwards a same-cycle field load, computes with the wrong descriptor.
- Hold and non-field opcodes. A design that ignores them raises a false valid or overwrites a held result.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int DESC_W = 1 + 2 * CNT_W;

  typedef struct packed {
    logic             ins;
    logic [CNT_W-1:0] msk;
    logic [CNT_W-1:0] sh;
  } fdesc_t;
endpackage

// File: rtl/fu_mask_gen.sv
module fu_mask_gen #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  ones
);
  // Bit i is set when the count exceeds i; counts above W fill the word.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign ones[i] = (cnt > CW'(i));
  end
endmodule

// File: rtl/fu_shifter.sv
module fu_shifter #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  left,
  input  logic [W-1:0]  right,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  shout
);
  localparam logic [CW-1:0] MAXC = CW'(W);

  logic [CW-1:0]  eff;
  logic [2*W-1:0] wide;

  always_comb begin
    eff   = (cnt > MAXC) ? MAXC : cnt;
    wide  = {left, right} << eff;
    shout = wide[2*W-1:W];
  end
endmodule

// File: rtl/fu_merge.sv
module fu_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] mask_m,
  input  logic [W-1:0] mask_s,
  input  logic         ins,
  input  logic [W-1:0] shout,
  input  logic [W-1:0] right,
  output logic [W-1:0] res
);
  logic [W-1:0] win;
  logic [W-1:0] insv;

  always_comb begin
    insv = {W{ins}};
    win  = mask_m ^ (mask_s & insv);
    res  = (win & shout) | (~win & right & insv);
  end
endmodule

// File: rtl/field_unit.sv
module field_unit
  import fu_pkg::*;
#(
  parameter int OP_W    = 5,
  parameter int OP_FREG = 9,
  parameter int OP_FIMM = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [DESC_W-1:0] kimm_i,
  input  logic [DESC_W-1:0] field_din_i,
  input  logic              field_load_i,
  input  logic              hold_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  localparam logic [OP_W-1:0] FREG = OP_W'(OP_FREG);
  localparam logic [OP_W-1:0] FIMM = OP_W'(OP_FIMM);

  fdesc_t            imm_q, field_q, desc;
  logic              is_field;
  logic [DATA_W-1:0] mask1, mask2, shout, merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      imm_q   <= '0;
      field_q <= '0;
    end else begin
      imm_q <= fdesc_t'(kimm_i);
      if (field_load_i) field_q <= fdesc_t'(field_din_i);
    end
  end

  assign is_field = (op_i == FREG) || (op_i == FIMM);
  assign desc     = (op_i == FIMM) ? imm_q : field_q;

  fu_mask_gen #(.W(DATA_W), .CW(CNT_W)) u_mask_m (.cnt(desc.msk), .ones(mask1));
  fu_mask_gen #(.W(DATA_W), .CW(CNT_W)) u_mask_s (.cnt(desc.sh),  .ones(mask2));

  fu_shifter #(.W(DATA_W), .CW(CNT_W)) u_shift (
    .left(left_i), .right(right_i), .cnt(desc.sh), .shout(shout)
  );

  fu_merge #(.W(DATA_W)) u_merge (
    .mask_m(mask1), .mask_s(mask2), .ins(desc.ins),
    .shout(shout), .right(right_i), .res(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= is_field && !hold_i;
      if (is_field && !hold_i) result_o <= merged;
    end
  end

  p_valid_src_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(is_field && !hold_i));

  p_no_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (!is_field || hold_i) |=> !valid_o);

  p_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (!is_field || hold_i) |=> $stable(result_o));

  p_mask_contig_r5: assert property (@(posedge clk) disable iff (rst)
    ((mask1 & (mask1 + 1'b1)) == '0));

  p_shift0_r3: assert property (@(posedge clk) disable iff (rst)
    (desc.sh == '0) |-> (shout == left_i));

  p_shift32_r3: assert property (@(posedge clk) disable iff (rst)
    (desc.sh >= CNT_W'(DATA_W)) |-> (shout == right_i));

  p_extract_r2: assert property (@(posedge clk) disable iff (rst)
    !desc.ins |-> ((merged & ~mask1) == '0));

  p_field_load_r6: assert property (@(posedge clk) disable iff (rst)
    field_load_i |=> (field_q == fdesc_t'($past(field_din_i))));
endmodule

// File: tb/tb_field_unit.sv
`timescale 1ns/1ps
module tb_field_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [31:0] left_i = '0, right_i = '0;
  logic [12:0] kimm_i = '0, field_din_i = '0;
  logic        field_load_i = 1'b0, hold_i = 1'b0;
  logic [31:0] result_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;

  field_unit dut (
    .clk(clk), .rst(rst), .op_i(op_i), .left_i(left_i), .right_i(right_i),
    .kimm_i(kimm_i), .field_din_i(field_din_i), .field_load_i(field_load_i),
    .hold_i(hold_i), .result_o(result_o), .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;

  // {ins, mask, shift, left, right}
  localparam int NV = 10;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 6'd8,  6'd4,  32'h12345678, 32'h9ABCDEF0},
    {1'b0, 6'd32, 6'd0,  32'hDEADBEEF, 32'h01234567},
    {1'b0, 6'd32, 6'd32, 32'hDEADBEEF, 32'h01234567},
    {1'b0, 6'd0,  6'd7,  32'hFFFFFFFF, 32'hFFFFFFFF},
    {1'b0, 6'd16, 6'd20, 32'hA5A5C3C3, 32'h0F0F7E7E},
    {1'b1, 6'd12, 6'd4,  32'h12345678, 32'h9ABCDEF0},
    {1'b1, 6'd24, 6'd8,  32'h000000AB, 32'h55555555},
    {1'b1, 6'd32, 6'd31, 32'h80000001, 32'hCAFEF00D},
    {1'b1, 6'd5,  6'd5,  32'h13579BDF, 32'h2468ACE0},
    {1'b0, 6'd50, 6'd45, 32'h11112222, 32'h33334444}
  };

  function automatic logic [31:0] ones(input logic [5:0] k);
    ones = '0;
    for (int i = 0; i < 32; i++) if (k > 6'(i)) ones[i] = 1'b1;
  endfunction

  function automatic logic [31:0] model(input logic ins, input logic [5:0] mk,
                                        input logic [5:0] sh, input logic [31:0] l,
                                        input logic [31:0] r);
    logic [63:0] w;
    logic [31:0] win;
    logic [5:0]  s;
    s   = (sh > 6'd32) ? 6'd32 : sh;
    w   = {l, r} << s;
    win = ones(mk) ^ (ins ? ones(s) : 32'h0);
    model = (win & w[63:32]) | (~win & r & {32{ins}});
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Immediate-driven field op: descriptor set one cycle ahead (R7).
  task automatic run_imm(input logic [12:0] d, input logic [31:0] l, input logic [31:0] r);
    kimm_i = d;
    step();
    op_i = 5'd10; left_i = l; right_i = r;
    step();
    op_i = 5'd0;
  endtask

  logic [31:0] saved;

  initial begin
    repeat (3) step();
    rst = 1'b0;
    check("R1 result after reset", result_o, 32'h0);
    check("R1 valid after reset", {31'h0, valid_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      v = VEC[i];
      run_imm(v[76:64], v[63:32], v[31:0]);
      check($sformatf("R2/R4 vector %0d result", i), result_o,
            model(v[76], v[75:70], v[69:64], v[63:32], v[31:0]));
      check($sformatf("R8 vector %0d valid", i), {31'h0, valid_o}, 32'h1);
    end

    run_imm({1'b0, 6'd8, 6'd4}, 32'h12345678, 32'h9ABCDEF0);
    check("R2 extract byte", result_o, 32'h00000089);
    run_imm({1'b1, 6'd12, 6'd4}, 32'h12345678, 32'h9ABCDEF0);
    check("R4 insert window", result_o, 32'h9ABCD780);
    run_imm({1'b0, 6'd32, 6'd0}, 32'h76543210, 32'hFEDCBA98);
    check("R3 shift zero gives left", result_o, 32'h76543210);
    run_imm({1'b0, 6'd32, 6'd32}, 32'h76543210, 32'hFEDCBA98);
    check("R3 shift 32 gives right", result_o, 32'hFEDCBA98);
    run_imm({1'b0, 6'd63, 6'd45}, 32'h11111111, 32'hCAFEF00D);
    check("R5 clamped counts", result_o, 32'hCAFEF00D);

    // R7: immediate changed in the same cycle as the op is not used yet.
    kimm_i = {1'b0, 6'd4, 6'd0};
    step();
    op_i = 5'd10; left_i = 32'h000000FF; right_i = 32'h0;
    kimm_i = {1'b0, 6'd8, 6'd0};
    step();
    op_i = 5'd0;
    check("R7 previous immediate used", result_o, 32'h0000000F);

    // R6: load field register, then opcode 9.
    field_load_i = 1'b1; field_din_i = {1'b0, 6'd16, 6'd8};
    step();
    field_load_i = 1'b0;
    op_i = 5'd9; left_i = 32'hAABBCCDD; right_i = 32'h11223344;
    step();
    op_i = 5'd0;
    check("R6 field register extract", result_o, 32'h0000DD11);

    // R6: load and use in the same cycle uses the old contents.
    field_load_i = 1'b1; field_din_i = {1'b0, 6'd4, 6'd0};
    op_i = 5'd9; left_i = 32'hAABBCCDD; right_i = 32'h11223344;
    step();
    field_load_i = 1'b0;
    check("R6 same-cycle load uses old", result_o, 32'h0000DD11);
    step();
    op_i = 5'd0;
    check("R6 new contents next", result_o, 32'h0000000D);

    // R9/R8: hold with a field op.
    step();
    saved = result_o;
    hold_i = 1'b1; op_i = 5'd10; left_i = 32'hFFFFFFFF;
    step();
    hold_i = 1'b0; op_i = 5'd0;
    check("R9 hold keeps result", result_o, saved);
    check("R8 hold gives no valid", {31'h0, valid_o}, 32'h0);

    // R9/R8: non-field opcodes.
    op_i = 5'd3; left_i = 32'h12121212;
    step();
    check("R9 other opcode keeps result", result_o, saved);
    check("R8 other opcode no valid", {31'h0, valid_o}, 32'h0);
    op_i = 5'd11;
    step();
    op_i = 5'd0;
    check("R8 opcode 11 no valid", {31'h0, valid_o}, 32'h0);

    // R1: reset again clears outputs and field register.
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 result on re-reset", result_o, 32'h0);
    op_i = 5'd9; left_i = 32'hFFFFFFFF; right_i = 32'hFFFFFFFF;
    step();
    op_i = 5'd0;
    check("R1 field register cleared", result_o, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule